// File: doc/BRIEF.md
# Configuration Image Header Section Locator

This block sits on a byte stream that carries the start of a configuration image. It first checks that the stream opens with a fixed thirteen-byte signature. It then walks the chain of tagged sections that follows, looking for one section letter that the caller requests. Each section is made of three parts, in order: a one-byte ASCII letter, a big-endian length, and then that many content bytes. Sections that do not match are read and thrown away.

When the requested section turns up, the block reports its length and stops taking bytes. The section's content is left unread at the head of the stream, so a downstream consumer can take over exactly at the first content byte. This is how the payload section is handed on.

The search has four ways to fail, and each has its own error flag: a wrong signature byte, an unknown section letter, a short-form length that is too big, or a search that runs out of its byte budget. Every search ends with a single-cycle done pulse. The result stays on the outputs until the next start.

Top module: `bsect_parser`

## Requirements
- R1: After reset, in_ready, done, found, all four error flags and sect_len are 0.
- R2: The first 13 bytes accepted after start are compared against 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order. At the first byte that differs, the search ends with err_sig set, and no further byte is accepted.
- R3: Letters 'a' (0x61) to 'd' (0x64) carry a 2-byte length. Letter 'e' (0x65) carries a 4-byte length. Both are most significant byte first.
- R4: A letter byte below 0x61 or above 0x65 ends the search with err_tag set.
- R5: For any letter other than 'e', a length above SHORT_MAX (255) ends the search with err_len set, even when the letter is the requested one. A found non-'e' section therefore always reports a length of at most 255.
- R6: When the letter equals the requested one, the search ends with found set and sect_len equal to the decoded length. The last byte accepted is the last length byte.
- R7: The content bytes of a section that does not match are accepted and discarded. A zero-length section goes straight on to the next letter.
- R8: The bytes after the signature (letters, length bytes and skipped content) are counted. Before each letter and before each skipped content byte, a count of BUDGET (100) or more ends the search with err_budget set. Length bytes are always read once their letter has been accepted.
- R9: done is a one-cycle pulse. From the done pulse until the next start, in_ready is 0, and found, the error flags and sect_len hold their values.
- R10: want_tag is sampled only on the start cycle. Changing it during a search does not affect that search's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search; taken only while idle |
| want_tag | input | 8 | ASCII letter of the section to find |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts in_data this cycle |
| done | output | 1 | One-cycle pulse when a search ends |
| found | output | 1 | Requested section located |
| sect_len | output | LEN_W | Decoded length of the located section |
| err_sig | output | 1 | Signature mismatch |
| err_tag | output | 1 | Unknown section letter |
| err_len | output | 1 | Short-form length above SHORT_MAX |
| err_budget | output | 1 | Byte budget used up |

## Verification
Faults inside the block show up at the ports in two ways:
- A wrong signature index, length-byte count or skip counter shifts the point where the block stops taking bytes. The bench counts accepted handshakes, so this is caught in the same search, at the done pulse.
- A wrong budget count or letter decode turns a found result into a different error flag, or the other way round. This shows up when the flags are compared against the model at done.

Leftover state that leaks into the next search is caught by the next search, because every case starts from start with a fresh expected value.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SIG,
      ST_TAG,
      ST_LEN,
      ST_SKIP
   } bsp_state_e;

   localparam int unsigned SIG_BYTES = 13;
   localparam logic [7:0]  TAG_FIRST = 8'h61;
   localparam logic [7:0]  TAG_LAST  = 8'h65;
   localparam logic [7:0]  TAG_WIDE  = 8'h65;

   // Signature byte at position i: 00 09, then four 0F F0 pairs, then 00 00 01
   function automatic logic [7:0] sig_byte(input logic [3:0] i);
      logic [7:0] b;
      if (i == 4'd0)
         b = 8'h00;
      else if (i == 4'd1)
         b = 8'h09;
      else if (i <= 4'd9)
         b = i[0] ? 8'hF0 : 8'h0F;
      else if (i == 4'd12)
         b = 8'h01;
      else
         b = 8'h00;
      return b;
   endfunction

endpackage

// File: rtl/bsp_sig_match.sv
module bsp_sig_match
   import bsp_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       byte_in,
   output logic             match,
   output logic             last
);

   if (IDX_W < 4) begin : g_bad_idx
      $error("bsp_sig_match: IDX_W must cover the signature length");
   end

   always_comb begin
      match = (byte_in == sig_byte(idx[3:0]));
      last  = (idx == IDX_W'(SIG_BYTES - 1));
   end

endmodule

// File: rtl/bsp_budget.sv
module bsp_budget #(
   parameter int unsigned LIMIT = 100,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic             exhausted
);

   logic [CNT_W-1:0] cnt;

   if (CNT_W < $clog2(LIMIT + 8)) begin : g_bad_w
      $error("bsp_budget: CNT_W too narrow for LIMIT");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + 1'b1;
   end

   assign exhausted = (cnt >= CNT_W'(LIMIT));

   // R8: only length bytes may be read past the limit, at most four of them
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(LIMIT + 4));

   // R8: once the limit is reached, no further count without a clear
   a_r8_no_count_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > CNT_W'(LIMIT)) && !clear |=> cnt <= CNT_W'(LIMIT + 4));

endmodule

// File: rtl/bsp_len_acc.sv
module bsp_len_acc #(
   parameter int unsigned LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift,
   input  logic [7:0]       byte_in,
   output logic [LEN_W-1:0] next_val
);

   logic [LEN_W-1:0] acc;

   if (LEN_W < 32) begin : g_bad_len
      $error("bsp_len_acc: LEN_W must hold a four-byte length");
   end

   assign next_val = {acc[LEN_W-9:0], byte_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clear)
         acc <= '0;
      else if (shift)
         acc <= next_val;
   end

   // R3: each shift brings the new byte into the low end of the value
   a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      shift && !clear |=> acc[7:0] == $past(byte_in));

endmodule

// File: rtl/bsect_parser.sv
module bsect_parser
   import bsp_pkg::*;
#(
   parameter int unsigned LEN_W     = 32,
   parameter int unsigned BUDGET    = 100,
   parameter int unsigned SHORT_MAX = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       want_tag,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             done,
   output logic             found,
   output logic [LEN_W-1:0] sect_len,
   output logic             err_sig,
   output logic             err_tag,
   output logic             err_len,
   output logic             err_budget
);

   localparam int unsigned IDX_W = $clog2(SIG_BYTES) + 1;
   localparam int unsigned CNT_W = $clog2(BUDGET + 8) + 1;

   if (BUDGET < 1) begin : g_bad_budget
      $error("bsect_parser: BUDGET must be at least 1");
   end
   if (SHORT_MAX >= 65536) begin : g_bad_short
      $error("bsect_parser: SHORT_MAX must fit a two-byte length");
   end

   bsp_state_e       state;
   logic [IDX_W-1:0] sig_idx;
   logic [7:0]       want_q;
   logic [7:0]       tag_q;
   logic [2:0]       len_left;
   logic [LEN_W-1:0] skip_rem;

   logic             accept;
   logic             sig_ok;
   logic             sig_last;
   logic             exhausted;
   logic             budget_clr;
   logic             budget_inc;
   logic             acc_clr;
   logic             acc_shift;
   logic [LEN_W-1:0] len_next;
   logic             tag_known;
   logic             len_too_big;

   bsp_sig_match #(.IDX_W(IDX_W)) u_sig (
      .idx     (sig_idx),
      .byte_in (in_data),
      .match   (sig_ok),
      .last    (sig_last)
   );

   bsp_budget #(.LIMIT(BUDGET), .CNT_W(CNT_W)) u_budget (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (budget_clr),
      .inc       (budget_inc),
      .exhausted (exhausted)
   );

   bsp_len_acc #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (acc_clr),
      .shift    (acc_shift),
      .byte_in  (in_data),
      .next_val (len_next)
   );

   always_comb begin
      unique case (state)
         ST_SIG:  in_ready = 1'b1;
         ST_TAG:  in_ready = !exhausted;
         ST_LEN:  in_ready = 1'b1;
         ST_SKIP: in_ready = !exhausted;
         default: in_ready = 1'b0;
      endcase
   end

   assign accept      = in_valid && in_ready;
   assign budget_clr  = (state == ST_IDLE);
   assign budget_inc  = accept && (state != ST_SIG);
   assign acc_clr     = (state == ST_TAG);
   assign acc_shift   = accept && (state == ST_LEN);
   assign tag_known   = (in_data >= TAG_FIRST) && (in_data <= TAG_LAST);
   assign len_too_big = (tag_q != TAG_WIDE) && (len_next > LEN_W'(SHORT_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sig_idx    <= '0;
         want_q     <= '0;
         tag_q      <= '0;
         len_left   <= '0;
         skip_rem   <= '0;
         done       <= 1'b0;
         found      <= 1'b0;
         sect_len   <= '0;
         err_sig    <= 1'b0;
         err_tag    <= 1'b0;
         err_len    <= 1'b0;
         err_budget <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  want_q     <= want_tag;
                  sig_idx    <= '0;
                  found      <= 1'b0;
                  sect_len   <= '0;
                  err_sig    <= 1'b0;
                  err_tag    <= 1'b0;
                  err_len    <= 1'b0;
                  err_budget <= 1'b0;
                  state      <= ST_SIG;
               end
            end
            ST_SIG: begin
               if (accept) begin
                  if (!sig_ok) begin
                     err_sig <= 1'b1;
                     done    <= 1'b1;
                     state   <= ST_IDLE;
                  end else if (sig_last) begin
                     state <= ST_TAG;
                  end else begin
                     sig_idx <= sig_idx + 1'b1;
                  end
               end
            end
            ST_TAG: begin
               if (exhausted) begin
                  err_budget <= 1'b1;
                  done       <= 1'b1;
                  state      <= ST_IDLE;
               end else if (accept) begin
                  if (!tag_known) begin
                     err_tag <= 1'b1;
                     done    <= 1'b1;
                     state   <= ST_IDLE;
                  end else begin
                     tag_q    <= in_data;
                     len_left <= (in_data == TAG_WIDE) ? 3'd4 : 3'd2;
                     state    <= ST_LEN;
                  end
               end
            end
            ST_LEN: begin
               if (accept) begin
                  len_left <= len_left - 1'b1;
                  if (len_left == 3'd1) begin
                     if (len_too_big) begin
                        err_len <= 1'b1;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                     end else if (tag_q == want_q) begin
                        found    <= 1'b1;
                        sect_len <= len_next;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                     end else if (len_next == '0) begin
                        state <= ST_TAG;
                     end else begin
                        skip_rem <= len_next;
                        state    <= ST_SKIP;
                     end
                  end
               end
            end
            ST_SKIP: begin
               if (exhausted) begin
                  err_budget <= 1'b1;
                  done       <= 1'b1;
                  state      <= ST_IDLE;
               end else if (accept) begin
                  skip_rem <= skip_rem - 1'b1;
                  if (skip_rem == LEN_W'(1))
                     state <= ST_TAG;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R9: done lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: nothing is accepted after a result unless a new search starts
   a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !in_ready);

   // R9: the result is held while idle
   a_r9_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !start |=> $stable(sect_len) && $stable(found));

   // R6: at most one outcome flag at a time
   a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({found, err_sig, err_tag, err_len, err_budget}));

   // R5: a found short-form section never reports more than SHORT_MAX
   a_r5_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done && found && (tag_q != TAG_WIDE) |-> sect_len <= LEN_W'(SHORT_MAX));

   // R10: the requested letter is fixed during a search
   a_r10_want_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(want_q));

endmodule

// File: tb/bsect_parser_test.sv
module bsect_parser_test;

   localparam int SLEN = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  want_tag = 8'h00;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic        done;
   logic        found;
   logic [31:0] sect_len;
   logic        err_sig;
   logic        err_tag;
   logic        err_len;
   logic        err_budget;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] stream [0:SLEN-1];
   int wp;

   always #2 clk = ~clk;

   bsect_parser uut (
      .clk(clk), .rst_n(rst_n), .start(start), .want_tag(want_tag),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .done(done), .found(found), .sect_len(sect_len),
      .err_sig(err_sig), .err_tag(err_tag), .err_len(err_len),
      .err_budget(err_budget)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] sig_at(input int i);
      logic [7:0] s [0:12];
      s = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
            8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
      return s[i];
   endfunction

   // outcome codes: 0 found, 1 signature, 2 letter, 3 length, 4 budget
   task automatic model(input logic [7:0] want, output int code,
                        output logic [31:0] len, output int used);
      int p;
      int cnt;
      logic [7:0] t;
      int nl;
      p = 0; cnt = 0; code = -1; len = 0;
      for (int k = 0; k < 13; k++) begin
         if (stream[p] != sig_at(k)) begin
            code = 1; used = p + 1; return;
         end
         p++;
      end
      forever begin
         if (cnt >= 100) begin code = 4; break; end
         t = stream[p]; p++; cnt++;
         if (t < 8'h61 || t > 8'h65) begin code = 2; break; end
         nl = (t == 8'h65) ? 4 : 2;
         len = 0;
         for (int j = 0; j < nl; j++) begin
            len = {len[23:0], stream[p]}; p++; cnt++;
         end
         if (t != 8'h65 && len > 255) begin code = 3; break; end
         if (t == want) begin code = 0; break; end
         for (longint j = 0; j < len; j++) begin
            if (cnt >= 100) break;
            p++; cnt++;
         end
      end
      if (code != 0) len = 0;
      used = p;
   endtask

   task automatic put(input logic [7:0] b);
      if (wp < SLEN) stream[wp] = b;
      wp++;
   endtask

   task automatic begin_stream();
      for (int i = 0; i < SLEN; i++) stream[i] = 8'($urandom);
      wp = 0;
      for (int i = 0; i < 13; i++) put(sig_at(i));
   endtask

   task automatic put_sect(input logic [7:0] t, input logic [31:0] l, input int body);
      put(t);
      if (t == 8'h65) begin put(l[31:24]); put(l[23:16]); end
      put(l[15:8]); put(l[7:0]);
      for (int i = 0; i < body; i++) put(8'($urandom));
   endtask

   task automatic run_case(input logic [7:0] want, input bit wiggle, input string req);
      int code; logic [31:0] elen; int used;
      int p; int guard; bit seen;
      logic [31:0] hold_len; logic [4:0] hold_flags;
      model(want, code, elen, used);
      @(negedge clk);
      start = 1'b1; want_tag = want;
      @(negedge clk);
      start = 1'b0;
      if (wiggle) want_tag = want ^ 8'h07;
      p = 0; guard = 0; seen = 0;
      while (guard < 2000) begin
         if (done) begin seen = 1; break; end
         if (p < SLEN) begin
            in_valid = 1'b1; in_data = stream[p];
            if (in_ready) p++;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
         guard++;
      end
      chk(seen, req, "done pulse seen", seen, 1);
      chk(found == (code == 0), req, "found", found, code == 0);
      chk(err_sig == (code == 1), "R2", "err_sig", err_sig, code == 1);
      chk(err_tag == (code == 2), "R4", "err_tag", err_tag, code == 2);
      chk(err_len == (code == 3), "R5", "err_len", err_len, code == 3);
      chk(err_budget == (code == 4), "R8", "err_budget", err_budget, code == 4);
      chk(sect_len == elen, "R6", "sect_len", sect_len, elen);
      chk(p == used, req, "bytes accepted", p, used);
      hold_len = sect_len;
      hold_flags = {found, err_sig, err_tag, err_len, err_budget};
      in_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!in_ready && !done, "R9", "idle after result ready/done", {in_ready, done}, 0);
         chk(sect_len == hold_len && {found, err_sig, err_tag, err_len, err_budget} == hold_flags,
             "R9", "result held", sect_len, hold_len);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #1;
      chk(!in_ready && !done && !found && !err_sig && !err_tag && !err_len && !err_budget
          && sect_len == 0, "R1", "reset state", {in_ready, done, found}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!in_ready && !done && sect_len == 0, "R1", "state after reset release",
          {in_ready, done}, 0);

      // R6 R3: first section matches, 2-byte length 5
      begin_stream(); put_sect(8'h61, 5, 5);
      run_case(8'h61, 1'b0, "R6");
      chk(sect_len == 5, "R3", "short length value", sect_len, 5);

      // R7 R3: skip 'a', then find 'e' with a 4-byte length
      begin_stream(); put_sect(8'h61, 3, 3); put_sect(8'h65, 32'h0001_2345, 0);
      run_case(8'h65, 1'b0, "R7");
      chk(sect_len == 32'h12345, "R3", "wide length value", sect_len, 32'h12345);

      // R2: last signature byte wrong
      begin_stream(); stream[12] = 8'h02;
      run_case(8'h61, 1'b0, "R2");
      // R2: first signature byte wrong
      begin_stream(); stream[0] = 8'h80;
      run_case(8'h61, 1'b0, "R2");

      // R4: letter 'f' and letter 0x60
      begin_stream(); put(8'h66);
      run_case(8'h61, 1'b0, "R4");
      begin_stream(); put_sect(8'h62, 1, 1); put(8'h60);
      run_case(8'h61, 1'b0, "R4");

      // R5: requested short section with length 256
      begin_stream(); put_sect(8'h62, 32'h100, 0);
      run_case(8'h62, 1'b0, "R5");

      // R8 R7: unmatched 'e' with a 300-byte body exhausts the budget
      begin_stream(); put_sect(8'h65, 300, 300);
      run_case(8'h61, 1'b0, "R8");

      // R8 R7: chain of zero-length sections until the budget ends it
      begin_stream();
      for (int i = 0; i < 40; i++) put_sect(8'h61, 0, 0);
      run_case(8'h64, 1'b0, "R8");

      // R10: want_tag changed after start
      begin_stream(); put_sect(8'h63, 2, 2); put_sect(8'h64, 7, 7);
      run_case(8'h64, 1'b1, "R10");

      // random streams
      for (int r = 0; r < 60; r++) begin
         int kind;
         begin_stream();
         if ($urandom % 8 == 0) stream[$urandom % 13] ^= 8'(1 + $urandom % 255);
         while (wp < SLEN - 40) begin
            kind = $urandom % 20;
            if (kind == 0)
               put(($urandom % 2) ? 8'h66 : 8'h41);
            else if (kind == 1)
               put_sect(8'h61 + 8'($urandom % 4), 256 + $urandom % 256, 0);
            else begin
               int l;
               l = $urandom % 24;
               put_sect(8'h61 + 8'($urandom % 5), l, l);
            end
         end
         run_case(8'h61 + 8'($urandom % 5), r[0], "R7");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule